// File: doc/BRIEF.md
# Paged Program Address Sequencer

This block produces the fetch address for an 11-bit program store arranged as two blocks of sixteen pages, each page holding sixty-four words. A 6-bit word counter walks through the current page, while a 4-bit page register and a 1-bit block register select where that page sits. Neither the page nor the block changes by itself: software first writes a page buffer or a block buffer, and only a taken branch or a taken call moves those buffered values into the live registers.

An instruction decoder drives one control strobe per instruction: step, branch, call, return, load page buffer, set block buffer or clear block buffer. It also supplies a 6-bit word target, a 4-bit page immediate and the current status flag. Every branch and call depends on that flag. A call saves the return word, page and block on a three-entry stack, and a return restores them. The block also reports the status value that the instruction leaves behind, so the decoder can write it back into the flag.

Top module: `prog_addr_seq`

## Requirements
- R1: `fetch_addr_o` is bit 10 the block register, bits 9..6 the page register and bits 5..0 the word counter.
- R2: A step increments the word counter by one. The count wraps from 63 to 0 and never carries into the page or block.
- R3: Loading the page buffer from `page_imm_i` leaves the fetch address unchanged. The new page shows up only after the next taken branch or call.
- R4: The block buffer set and clear strobes leave the fetch address unchanged. If both are asserted together, set wins.
- R5: A branch with `status_i`=1 loads the word counter from `target_i`, the page register from the page buffer and the block register from the block buffer.
- R6: A branch or call with `status_i`=0 only increments the word counter and drives `status_o`=1. With no transfer and no return, `status_o` equals `status_i`.
- R7: A call with `status_i`=1 jumps as in R5 and pushes {block, page, word+1} onto the return stack.
- R8: A return loads the word counter, page register, page buffer, block register and block buffer from the top stack entry, and drives `status_o`=1. Its page buffer write takes precedence over a page-buffer load in the same cycle.
- R9: The stack holds three entries. A fourth nested call discards the oldest entry. Each pop moves the entries up and copies the bottom entry into the freed slot, so returns beyond the depth keep yielding that entry.
- R10: Reset clears the word counter, page register, block register, both buffers and the stack, so the fetch address is 0.
- R11: When a buffer load falls in the same cycle as a taken branch or call, the transfer uses the old buffer value and the buffer keeps the new value afterwards.
- R12: When several transfer strobes are asserted together, the priority is return, then call, then branch, then step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Sequential instruction: advance word counter |
| br_i | input | 1 | Conditional branch strobe |
| cal_i | input | 1 | Conditional call strobe |
| rtn_i | input | 1 | Return strobe |
| ldpb_i | input | 1 | Load page buffer from page_imm_i |
| setbb_i | input | 1 | Set block buffer |
| clrbb_i | input | 1 | Clear block buffer |
| target_i | input | 6 | Word target of branch or call |
| page_imm_i | input | 4 | Page buffer immediate |
| status_i | input | 1 | Current status flag |
| fetch_addr_o | output | 11 | Fetch address {block, page, word} |
| status_o | output | 1 | Status value after this instruction |

## Verification
Two operations can fall in the same cycle: a buffer load and the taken call or branch that commits that buffer. The bench provokes this by loading a new page, clearing the block buffer and issuing a taken call on one edge. It checks that the call lands on the old page and block, and that the following taken branch lands on the new ones. A return asserted together with step and branch is also checked, and only the return's destination is accepted.

// File: rtl/pas_pkg.sv
package pas_pkg;
   typedef enum logic [2:0] {
      CMD_IDLE = 3'd0,
      CMD_STEP = 3'd1,
      CMD_BR   = 3'd2,
      CMD_CAL  = 3'd3,
      CMD_RTN  = 3'd4
   } pas_cmd_e;
endpackage

// File: rtl/pas_word_ctr.sv
module pas_word_ctr #(
   parameter int WORD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_en,
   input  logic              load_en,
   input  logic [WORD_W-1:0] load_val,
   output logic [WORD_W-1:0] word_q
);
   localparam logic [WORD_W-1:0] WORD_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)       word_q <= '0;
      else if (load_en) word_q <= load_val;
      else if (inc_en)  word_q <= word_q + WORD_W'(1);
   end

   // R2
   word_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !load_en) |=> word_q == $past(word_q) + WORD_W'(1));

   // R2
   word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !load_en && word_q == WORD_MAX) |=> word_q == '0);
endmodule

// File: rtl/pas_bank_regs.sv
module pas_bank_regs #(
   parameter int PAGE_W        = 4,
   parameter bit RESTORE_BLOCK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic              restore,
   input  logic [PAGE_W-1:0] rest_page,
   input  logic              rest_block,
   input  logic              ldpb,
   input  logic [PAGE_W-1:0] page_imm,
   input  logic              setbb,
   input  logic              clrbb,
   output logic [PAGE_W-1:0] page_q,
   output logic              block_q
);
   logic [PAGE_W-1:0] pbuf_q;
   logic              bbuf_q;
   logic              blk_rest;

   assign blk_rest = restore && RESTORE_BLOCK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= '0;
         pbuf_q <= '0;
      end else begin
         if (restore)     page_q <= rest_page;
         else if (commit) page_q <= pbuf_q;
         if (restore)     pbuf_q <= rest_page;
         else if (ldpb)   pbuf_q <= page_imm;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         block_q <= 1'b0;
         bbuf_q  <= 1'b0;
      end else begin
         if (blk_rest)    block_q <= rest_block;
         else if (commit) block_q <= bbuf_q;
         if (blk_rest)    bbuf_q  <= rest_block;
         else if (setbb)  bbuf_q  <= 1'b1;
         else if (clrbb)  bbuf_q  <= 1'b0;
      end
   end

   // R3
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !restore) |=> $stable(page_q));

   // R11
   commit_old_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !restore) |=> page_q == $past(pbuf_q) && block_q == $past(bbuf_q));

   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (setbb && clrbb && !blk_rest) |=> bbuf_q);
endmodule

// File: rtl/pas_ret_stack.sv
module pas_ret_stack #(
   parameter int DEPTH = 3,
   parameter int ENT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [ENT_W-1:0] push_data,
   output logic [ENT_W-1:0] top_q
);
   logic [ENT_W-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [ENT_W-1:0] from_above;
      logic [ENT_W-1:0] from_below;
      if (i == 0) begin : g_head
         assign from_above = push_data;
      end else begin : g_body
         assign from_above = ent[i-1];
      end
      if (i == DEPTH-1) begin : g_tail
         assign from_below = ent[i];
      end else begin : g_mid
         assign from_below = ent[i+1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)    ent[i] <= '0;
         else if (push) ent[i] <= from_above;
         else if (pop)  ent[i] <= from_below;
      end
   end

   assign top_q = ent[0];

   // R7
   push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top_q == $past(push_data));

   // R9
   bottom_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> ent[DEPTH-1] == $past(ent[DEPTH-1]));
endmodule

// File: rtl/prog_addr_seq.sv
module prog_addr_seq
   import pas_pkg::*;
#(
   parameter int WORD_W      = 6,
   parameter int PAGE_W      = 4,
   parameter int STACK_DEPTH = 3,
   parameter bit SAVE_BLOCK  = 1'b1,
   localparam int ADDR_W     = WORD_W + PAGE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              br_i,
   input  logic              cal_i,
   input  logic              rtn_i,
   input  logic              ldpb_i,
   input  logic              setbb_i,
   input  logic              clrbb_i,
   input  logic [WORD_W-1:0] target_i,
   input  logic [PAGE_W-1:0] page_imm_i,
   input  logic              status_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic              status_o
);
   localparam int ENT_W = WORD_W + PAGE_W + (SAVE_BLOCK ? 1 : 0);

   if (WORD_W < 1 || PAGE_W < 1) begin : g_bad_width
      $error("prog_addr_seq: widths must be positive");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("prog_addr_seq: stack depth must be positive");
   end

   pas_cmd_e          cmd;
   logic              xfer, taken, wc_inc, wc_load;
   logic [WORD_W-1:0] word_q, wc_val, ret_word;
   logic [PAGE_W-1:0] page_q, stk_page;
   logic              block_q, stk_block;
   logic [ENT_W-1:0]  push_data, stk_top;

   always_comb begin
      if (rtn_i)       cmd = CMD_RTN;
      else if (cal_i)  cmd = CMD_CAL;
      else if (br_i)   cmd = CMD_BR;
      else if (step_i) cmd = CMD_STEP;
      else             cmd = CMD_IDLE;
   end

   assign xfer     = (cmd == CMD_BR) || (cmd == CMD_CAL);
   assign taken    = xfer && status_i;
   assign wc_inc   = (cmd == CMD_STEP) || (xfer && !status_i);
   assign wc_load  = taken || (cmd == CMD_RTN);
   assign ret_word = word_q + WORD_W'(1);
   assign stk_page = stk_top[WORD_W +: PAGE_W];
   assign wc_val   = (cmd == CMD_RTN) ? stk_top[WORD_W-1:0] : target_i;
   assign status_o = ((cmd == CMD_RTN) || (xfer && !status_i)) ? 1'b1 : status_i;

   if (SAVE_BLOCK) begin : g_blk_saved
      assign push_data = {block_q, page_q, ret_word};
      assign stk_block = stk_top[ENT_W-1];
   end else begin : g_blk_kept
      assign push_data = {page_q, ret_word};
      assign stk_block = 1'b0;
   end

   pas_word_ctr #(.WORD_W(WORD_W)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_en   (wc_inc),
      .load_en  (wc_load),
      .load_val (wc_val),
      .word_q   (word_q)
   );

   pas_bank_regs #(.PAGE_W(PAGE_W), .RESTORE_BLOCK(SAVE_BLOCK)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (taken),
      .restore    (cmd == CMD_RTN),
      .rest_page  (stk_page),
      .rest_block (stk_block),
      .ldpb       (ldpb_i),
      .page_imm   (page_imm_i),
      .setbb      (setbb_i),
      .clrbb      (clrbb_i),
      .page_q     (page_q),
      .block_q    (block_q)
   );

   pas_ret_stack #(.DEPTH(STACK_DEPTH), .ENT_W(ENT_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (taken && (cmd == CMD_CAL)),
      .pop       (cmd == CMD_RTN),
      .push_data (push_data),
      .top_q     (stk_top)
   );

   assign fetch_addr_o = {block_q, page_q, word_q};

   // R8
   rtn_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rtn_i |-> status_o);

   // R6
   not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rtn_i && (br_i || cal_i) && !status_i) |=>
         fetch_addr_o[ADDR_W-1:WORD_W] == $past(fetch_addr_o[ADDR_W-1:WORD_W]));

   // R5
   taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rtn_i && (br_i || cal_i) && status_i) |=>
         fetch_addr_o[WORD_W-1:0] == $past(target_i));
endmodule

// File: tb/prog_addr_seq_tb.sv
`timescale 1ns/1ps
module prog_addr_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 0, br_i = 0, cal_i = 0, rtn_i = 0;
   logic        ldpb_i = 0, setbb_i = 0, clrbb_i = 0;
   logic [5:0]  target_i = '0;
   logic [3:0]  page_imm_i = '0;
   logic        status_i = 1'b0;
   logic [10:0] fetch_addr_o;
   logic        status_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   prog_addr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_i(br_i), .cal_i(cal_i),
      .rtn_i(rtn_i), .ldpb_i(ldpb_i), .setbb_i(setbb_i), .clrbb_i(clrbb_i),
      .target_i(target_i), .page_imm_i(page_imm_i), .status_i(status_i),
      .fetch_addr_o(fetch_addr_o), .status_o(status_o)
   );

   typedef struct packed {
      logic [2:0]  cmd;   // 0 idle 1 step 2 br 3 cal 4 rtn
      logic        lp;
      logic [3:0]  pimm;
      logic        sb;
      logic        cb;
      logic [5:0]  tgt;
      logic        st;
      logic [10:0] eaddr;
      logic        est;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 1'b0, 4'd0, 1'b0, 1'b0, 6'd0,  1'b1, 11'h001, 1'b1, 4'd2},  // R2 step
      '{3'd0, 1'b1, 4'd5, 1'b0, 1'b0, 6'd0,  1'b0, 11'h001, 1'b0, 4'd3},  // R3 buffer only, status passes
      '{3'd2, 1'b0, 4'd0, 1'b0, 1'b0, 6'd16, 1'b0, 11'h002, 1'b1, 4'd6},  // R6 branch not taken
      '{3'd2, 1'b0, 4'd0, 1'b0, 1'b0, 6'd16, 1'b1, 11'h150, 1'b1, 4'd5},  // R5 taken branch to page 5
      '{3'd0, 1'b0, 4'd0, 1'b1, 1'b0, 6'd0,  1'b0, 11'h150, 1'b0, 4'd4},  // R4 set block buffer
      '{3'd3, 1'b0, 4'd0, 1'b0, 1'b0, 6'd63, 1'b1, 11'h57F, 1'b1, 4'd1},  // R1 R7 taken call to block 1
      '{3'd1, 1'b0, 4'd0, 1'b0, 1'b0, 6'd0,  1'b1, 11'h540, 1'b1, 4'd2},  // R2 wrap stays on page
      '{3'd3, 1'b1, 4'd9, 1'b0, 1'b1, 6'd2,  1'b1, 11'h542, 1'b1, 4'd11}, // R11 old buffers used
      '{3'd2, 1'b0, 4'd0, 1'b0, 1'b0, 6'd7,  1'b1, 11'h247, 1'b1, 4'd11}, // R11 new buffers held
      '{3'd4, 1'b0, 4'd0, 1'b0, 1'b0, 6'd0,  1'b0, 11'h541, 1'b1, 4'd8},  // R8 return across block
      '{3'd4, 1'b0, 4'd0, 1'b0, 1'b0, 6'd0,  1'b0, 11'h151, 1'b1, 4'd8},  // R8 second return
      '{3'd3, 1'b0, 4'd0, 1'b0, 1'b0, 6'd1,  1'b0, 11'h152, 1'b1, 4'd6}   // R6 call not taken
   };

   task automatic chk(input int req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL R%0d %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic s, b, c, r, lp, input logic [3:0] pi,
                        input logic sb, cb, input logic [5:0] tg, input logic st,
                        input logic est, input logic [10:0] ea, input int req);
      @(negedge clk);
      step_i = s; br_i = b; cal_i = c; rtn_i = r; ldpb_i = lp; page_imm_i = pi;
      setbb_i = sb; clrbb_i = cb; target_i = tg; status_i = st;
      #1;
      chk(req, "status", int'(status_o), int'(est));
      @(posedge clk);
      #1;
      chk(req, "addr", int'(fetch_addr_o), int'(ea));
   endtask

   task automatic idle();
      @(negedge clk);
      step_i = 0; br_i = 0; cal_i = 0; rtn_i = 0; ldpb_i = 0; setbb_i = 0; clrbb_i = 0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(10, "reset addr", int'(fetch_addr_o), 0);   // R10
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].cmd == 3'd1, VECS[i].cmd == 3'd2, VECS[i].cmd == 3'd3,
               VECS[i].cmd == 3'd4, VECS[i].lp, VECS[i].pimm, VECS[i].sb,
               VECS[i].cb, VECS[i].tgt, VECS[i].st, VECS[i].est,
               VECS[i].eaddr, int'(VECS[i].req));
      end

      // R9 four nested calls on page 5, then five returns
      apply(0,0,1,0,0,4'd0,0,0,6'd10,1,1,11'h14A,9);
      apply(0,0,1,0,0,4'd0,0,0,6'd20,1,1,11'h154,9);
      apply(0,0,1,0,0,4'd0,0,0,6'd30,1,1,11'h15E,9);
      apply(0,0,1,0,0,4'd0,0,0,6'd40,1,1,11'h168,9);
      apply(0,0,0,1,0,4'd0,0,0,6'd0, 0,1,11'h15F,9);
      apply(0,0,0,1,0,4'd0,0,0,6'd0, 0,1,11'h155,9);
      apply(0,0,0,1,0,4'd0,0,0,6'd0, 0,1,11'h14B,9);
      apply(0,0,0,1,0,4'd0,0,0,6'd0, 0,1,11'h14B,9);
      // R12 return beats step and branch
      apply(1,1,0,1,0,4'd0,0,0,6'd0, 1,1,11'h14B,12);
      // R8 return page buffer write beats a same-cycle load of page 3
      apply(0,0,0,1,1,4'd3,0,0,6'd0, 1,1,11'h14B,8);
      apply(0,1,0,0,0,4'd0,0,0,6'd9, 1,1,11'h149,8);
      // R4 set and clear together: set wins, address untouched
      apply(0,0,0,0,0,4'd0,1,1,6'd0, 1,1,11'h149,4);
      apply(0,1,0,0,0,4'd0,0,0,6'd0, 1,1,11'h540,4);
      idle();

      // R10 reset mid-run clears registers and buffers
      rst_n = 1'b0;
      @(posedge clk); #1;
      chk(10, "reset addr", int'(fetch_addr_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      apply(0,1,0,0,0,4'd0,0,0,6'd3,1,1,11'h003,10);
      idle();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule